// File: doc/BRIEF.md
# Thirteen-Phase Clock and Data Recovery

This block rebuilds a bit clock and the bit stream from two pulse-detect rails, one for positive marks and one for negative marks, as delivered by an analog slicer. It runs from a reference clock at N times the nominal bit rate, so each bit period holds N reference cycles, or phases. The rising edge of any mark, seen after a two-stage synchroniser on each rail, selects the phase nearest to its arrival. That phase then fixes the recovered clock and the point where a bit is closed and presented, until a later mark lands closer to a different phase.

A bit is closed half a period (N/2 phases) after the selected phase, so a mark that arrives up to N/2 phases early or late is still credited to the right bit. A bit with no mark comes out as zero on both data outputs. With no marks at all, the phase stays where it is and the recovered clock keeps running at the reference rate divided by N. The recovered clock is high for HIGH reference cycles. A configuration input picks which recovered-clock edge the data is valid on.

Top module: `cdr_phase_pick`

## Requirements
- R1: While reset is low, `rpos` and `rneg` are 0. After reset is released, `rclk` runs with rising edges exactly N reference cycles apart.
- R2: With both rails held low, `rclk` keeps a period of exactly N reference cycles and every recovered bit is 00 on {`rpos`,`rneg`}.
- R3: A mark on `pos_in` comes out as {`rpos`,`rneg`} = 10 for its bit, a mark on `neg_in` as 01, and a bit with no mark as 00, in the order the marks were sent.
- R4: Marks that arrive on a steady grid of N reference cycles give an `rclk` period of exactly N for every bit.
- R5: When a mark arrives d phases away from the held phase (|d| ≤ N/2), exactly one `rclk` period becomes N+d. Later marks on the shifted grid give period N again, and the data stream is not disturbed.
- R6: A one-phase shift gives a single period of N-1 (early) or N+1 (late). At N=13 that is 12 or 14.
- R7: The selected phase moves by at most MAXJ phases per mark, so every `rclk` period stays within N-MAXJ to N+MAXJ. At N=13 and MAXJ=6 that range is 7 to 19.
- R8: With `edge_sel` = 0, `rpos`/`rneg` change HIGH reference cycles before an `rclk` rising edge and never on a rising edge, so data is valid on the rising edge.
- R9: With `edge_sel` = 1, `rpos`/`rneg` change only in the reference cycle where `rclk` rises and hold through the following falling edge, so data is valid on the falling edge.
- R10: Each `rclk` high phase lasts exactly HIGH reference cycles. The default is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, N times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_in | input | 1 | Positive-mark detect rail, asynchronous |
| neg_in | input | 1 | Negative-mark detect rail, asynchronous |
| edge_sel | input | 1 | 0: data valid on rising `rclk`; 1: data valid on falling `rclk` |
| rclk | output | 1 | Recovered bit clock |
| rpos | output | 1 | Recovered positive-mark bit |
| rneg | output | 1 | Recovered negative-mark bit |

## Verification
The bench builds the block with its defaults: N=13 phases, a MAXJ of 6 and a 3-cycle high time. With these values a half-bit window is six phases each way, so marks displaced by the full ±6 phases can be sent. The two extreme periods, 7 and 19 reference cycles, can therefore be measured, along with the single-step periods of 12 and 14. At these defaults the MAXJ clamp coincides with the window edge. The rising-edge and falling-edge output timings are each checked on an alternating pattern of positive, negative and empty bits.

// File: rtl/cdr_phase_pick.sv
module cdr_phase_pick #(
  parameter int N    = 13,
  parameter int MAXJ = 6,
  parameter int HIGH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_in,
  input  logic neg_in,
  input  logic edge_sel,
  output logic rclk,
  output logic rpos,
  output logic rneg
);
  localparam int PW   = $clog2(N);
  localparam int SW   = PW + 2;
  localparam int HALF = N / 2;
  localparam int BW   = $clog2(2 * N + 1);
  localparam logic signed [SW-1:0] NS   = SW'(N);
  localparam logic signed [SW-1:0] HS   = SW'(HALF);
  localparam logic signed [SW-1:0] JMAX = SW'(MAXJ);
  localparam logic signed [SW-1:0] ZS   = '0;
  localparam logic signed [SW-1:0] ONE  = SW'(1);
  localparam logic [BW-1:0] HI_B  = BW'(HIGH);
  localparam logic [BW-1:0] HI2_B = BW'(2 * HIGH);
  localparam logic [BW-1:0] BT_MAX = '1;

  logic [1:0] psy, nsy;
  logic any_q, fp, fn, hit, tick;
  logic signed [SW-1:0] cnt, sel, sel_n, dm, step, sum, tsum;
  logic [BW-1:0] bt;

  assign hit = (psy[1] | nsy[1]) & ~any_q;

  always_comb begin
    dm = cnt - sel;
    if (dm < ZS) dm = dm + NS;
    step = (dm > HS) ? dm - NS : dm;
    if (step > JMAX) step = JMAX;
    else if (step < -JMAX) step = -JMAX;
    sum = sel + step;
    if (sum < ZS) sum = sum + NS;
    else if (sum >= NS) sum = sum - NS;
    sel_n = hit ? sum : sel;
    tsum = sel_n + HS;
    if (tsum >= NS) tsum = tsum - NS;
  end

  assign tick = (cnt == tsum);
  assign rclk = edge_sel ? (bt < HI_B) : (bt >= HI_B && bt < HI2_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psy   <= '0;
      nsy   <= '0;
      any_q <= 1'b0;
      cnt   <= ZS;
      sel   <= ZS;
      bt    <= '0;
      fp    <= 1'b0;
      fn    <= 1'b0;
      rpos  <= 1'b0;
      rneg  <= 1'b0;
    end else begin
      psy   <= {psy[0], pos_in};
      nsy   <= {nsy[0], neg_in};
      any_q <= psy[1] | nsy[1];
      cnt   <= (cnt == NS - ONE) ? ZS : cnt + ONE;
      sel   <= sel_n;
      if (tick) begin
        rpos <= fp;
        rneg <= fn;
        fp   <= 1'b0;
        fn   <= 1'b0;
        bt   <= '0;
      end else begin
        if (bt != BT_MAX) bt <= bt + 1'b1;
        if (hit) begin
          fp <= fp | psy[1];
          fn <= fn | nsy[1];
        end
      end
    end
  end
endmodule

// File: rtl/cdr_phase_pick_chk.sv
module cdr_phase_pick_chk #(
  parameter int N    = 13,
  parameter int MAXJ = 6,
  parameter int HIGH = 3
) (
  input logic clk,
  input logic rst_n,
  input logic edge_sel,
  input logic rclk,
  input logic rpos,
  input logic rneg
);
  localparam int CW = $clog2(4 * N + 1);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] QMIN = CW'(2 * N);
  localparam logic [CW-1:0] PLO  = CW'(N - MAXJ);
  localparam logic [CW-1:0] PHI  = CW'(N + MAXJ);
  localparam logic [CW-1:0] HW   = CW'(HIGH);

  logic rclk_q, es_q, seen;
  logic [CW-1:0] per_cnt, hi_cnt, quiet;
  logic rise, fall, qok;

  assign rise = rclk & ~rclk_q;
  assign fall = ~rclk & rclk_q;
  assign qok  = (quiet >= QMIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rclk_q  <= 1'b0;
      es_q    <= 1'b0;
      seen    <= 1'b0;
      per_cnt <= '0;
      hi_cnt  <= '0;
      quiet   <= '0;
    end else begin
      rclk_q <= rclk;
      es_q   <= edge_sel;
      if (rise) seen <= 1'b1;
      if (rise) per_cnt <= CW'(1);
      else if (per_cnt != CMAX) per_cnt <= per_cnt + 1'b1;
      if (rclk) hi_cnt <= rclk_q ? hi_cnt + 1'b1 : CW'(1);
      if (edge_sel != es_q) quiet <= '0;
      else if (quiet != CMAX) quiet <= quiet + 1'b1;
    end
  end

  p_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && seen && qok) |-> (per_cnt >= PLO && per_cnt <= PHI));

  p_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && qok) |-> (hi_cnt == HW));

  p_rise_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !edge_sel && qok) |-> $stable({rpos, rneg}));

  p_fall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && edge_sel && qok) |-> $stable({rpos, rneg}));
endmodule

bind cdr_phase_pick cdr_phase_pick_chk #(.N(N), .MAXJ(MAXJ), .HIGH(HIGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel),
  .rclk(rclk), .rpos(rpos), .rneg(rneg)
);

// File: tb/cdr_phase_pick_tb.sv
`timescale 1ns/1ps
module cdr_phase_pick_tb;
  localparam int N = 13;
  localparam logic [27:0] PAT = 28'b10_01_00_10_00_00_01_10_01_00_00_00_10_01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pos_in = 1'b0, neg_in = 1'b0, edge_sel = 1'b0;
  logic rclk, rpos, rneg;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [1:0] samp [0:255];
  int pers [0:255];
  int ns = 0, np = 0, per_c = 0, hl = 0, hmin = 99, hmax = 0;
  int chg_rise = 0, chg_other = 0;
  logic r_q = 1'b0;
  logic [1:0] d_q = 2'b00;

  always #2 clk = ~clk;

  cdr_phase_pick u_dut (
    .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .neg_in(neg_in),
    .edge_sel(edge_sel), .rclk(rclk), .rpos(rpos), .rneg(rneg)
  );

  always @(negedge clk) begin
    logic rise, fall;
    logic [1:0] dat;
    rise = rclk && !r_q;
    fall = !rclk && r_q;
    dat = {rpos, rneg};
    if (rst_n) begin
      per_c = per_c + 1;
      if (rise) begin
        if (np < 256) pers[np] = per_c;
        np = np + 1;
        per_c = 0;
      end
      if (rise) hl = 1;
      else if (rclk) hl = hl + 1;
      if (fall) begin
        if (hl < hmin) hmin = hl;
        if (hl > hmax) hmax = hl;
      end
      if (edge_sel ? fall : rise) begin
        if (ns < 256) samp[ns] = dat;
        ns = ns + 1;
      end
      if (dat != d_q) begin
        if (rise) chg_rise = chg_rise + 1;
        else chg_other = chg_other + 1;
      end
    end
    r_q = rclk;
    d_q = dat;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_rec();
    ns = 0; np = 0; hmin = 99; hmax = 0; chg_rise = 0; chg_other = 0;
  endtask

  task automatic emit(input logic p, input logic n, input int len);
    pos_in = p;
    neg_in = n;
    repeat (5) @(negedge clk);
    pos_in = 1'b0;
    neg_in = 1'b0;
    repeat (len - 5) @(negedge clk);
  endtask

  task automatic lock_up();
    for (int i = 0; i < 3; i++) emit(1'b1, 1'b0, N);
    for (int i = 0; i < 2; i++) emit(1'b0, 1'b0, N);
  endtask

  function automatic int first_mark();
    for (int i = 0; i < ns && i < 256; i++)
      if (samp[i] != 2'b00) return i;
    return -1;
  endfunction

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(rpos == 1'b0 && rneg == 1'b0, "R1 reset outputs", {rpos, rneg}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    clear_rec();
    repeat (90) @(negedge clk);
    chk(np >= 5, "R1 clock running", np, 5);
    for (int i = 0; i < np && i < 256; i++)
      if (pers[i] != N) chk(1'b0, "R1 period", pers[i], N);
    chk(1'b1, "R1 periods", N, N);
  endtask

  task automatic t_idle();
    clear_rec();
    repeat (120) @(negedge clk);
    chk(np >= 8, "R2 free-run count", np, 8);
    for (int i = 0; i < np && i < 256; i++)
      if (pers[i] != N) chk(1'b0, "R2 free-run period", pers[i], N);
    for (int i = 0; i < ns && i < 256; i++)
      if (samp[i] != 2'b00) chk(1'b0, "R2 idle data", samp[i], 0);
    chk(first_mark() == -1, "R2 no marks", first_mark(), -1);
  endtask

  task automatic t_pattern(input logic pol);
    int f;
    edge_sel = pol;
    repeat (40) @(negedge clk);
    lock_up();
    clear_rec();
    for (int i = 13; i >= 0; i--) emit(PAT[2*i+1], PAT[2*i], N);
    for (int i = 0; i < 3; i++) emit(1'b0, 1'b0, N);
    repeat (20) @(negedge clk);
    f = first_mark();
    chk(f >= 0 && f + 14 <= ns, "R3 enough samples", ns, 14);
    if (f >= 0 && f + 14 <= ns && f + 14 <= 256)
      for (int i = 0; i < 14; i++)
        chk(samp[f+i] == PAT[2*(13-i) +: 2], "R3 bit value", samp[f+i], PAT[2*(13-i) +: 2]);
    for (int i = 0; i < np && i < 256; i++)
      if (pers[i] != N) chk(1'b0, "R4 steady period", pers[i], N);
    chk(np >= 14, "R4 period count", np, 14);
    chk(hmin == 3 && hmax == 3, "R10 high time", hmax, 3);
    if (!pol) begin
      chk(chg_rise == 0, "R8 no change on rise", chg_rise, 0);
      chk(chg_other > 0, "R8 data moved", chg_other, 1);
    end else begin
      chk(chg_other == 0, "R9 change only on rise", chg_other, 0);
      chk(chg_rise > 0, "R9 data moved", chg_rise, 1);
    end
  endtask

  task automatic t_disp(input int d, input string req);
    int f, odd, oddv;
    edge_sel = 1'b0;
    repeat (40) @(negedge clk);
    lock_up();
    clear_rec();
    emit(1'b1, 1'b0, N);
    emit(1'b1, 1'b0, N + d);
    for (int i = 0; i < 3; i++) emit(1'b1, 1'b0, N);
    for (int i = 0; i < 3; i++) emit(1'b0, 1'b0, N);
    repeat (20) @(negedge clk);
    odd = 0; oddv = N;
    for (int i = 0; i < np && i < 256; i++) begin
      if (pers[i] != N) begin odd = odd + 1; oddv = pers[i]; end
      if (pers[i] < N - 6 || pers[i] > N + 6) chk(1'b0, "R7 period range", pers[i], N);
    end
    chk(odd == 1, {req, " one shifted period"}, odd, 1);
    chk(oddv == N + d, {req, " shifted period"}, oddv, N + d);
    f = first_mark();
    chk(f >= 0 && f + 6 <= ns, {req, " sample count"}, ns, 6);
    if (f >= 0 && f + 6 <= ns && f + 6 <= 256) begin
      for (int i = 0; i < 5; i++)
        chk(samp[f+i] == 2'b10, {req, " data kept"}, samp[f+i], 2);
      chk(samp[f+5] == 2'b00, {req, " trailing zero"}, samp[f+5], 0);
    end
  endtask

  initial begin
    t_reset();
    t_idle();
    t_pattern(1'b0);
    t_disp(6, "R5 late max");
    t_disp(-6, "R5 early max");
    t_disp(3, "R5 late");
    t_disp(1, "R6 late one");
    t_disp(-1, "R6 early one");
    t_pattern(1'b1);
    edge_sel = 1'b0;
    repeat (40) @(negedge clk);
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule